// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block holds a small word-addressed memory that several requesters share. It carries out indivisible read-modify-write operations on that memory. A requester presents an opcode, a word address and two operands on a valid/ready channel. The unit returns the value the word held before the operation. For compare-and-swap it also returns a success flag. Besides plain loads and stores, it offers swap, test-and-set, fetch-and-add, fetch-and-increment and compare-and-swap. These are the primitives that locks, counters and barriers are built on in software.

A plain load or store finishes in one clock. An atomic operation occupies the unit for two clocks and locks the word it addresses during that time. While the word is locked, the request channel is held off. An external invalidation aimed at the locked word is also held off. Once the operation completes, the unit accepts the held invalidation, which clears the word. Invalidations aimed at other words are accepted at once. Software releases a lock with a plain store of zero, which completes in one clock.

Top module: `amo_unit`

## Requirements
- R1: After reset, every memory word reads as zero, `rsp_valid` and `rsp_ok` are low, and `req_ready` is high when no invalidation is presented.
- R2: Opcode 0 (load) and opcode 7 (reserved, treated as a load) return the word's value and leave it unchanged. Opcode 1 (store) returns the prior value and writes operand A. For an accepted plain operation, `rsp_valid` is high in the very next cycle.
- R3: Opcode 2 (swap) returns the prior value and writes operand A.
- R4: Opcode 3 (test-and-set) returns the prior value. It writes 1 only if that prior value was 0; otherwise the word is unchanged.
- R5: Opcode 4 (fetch-and-add) returns the prior value and writes the prior value plus operand A, wrapping modulo 2^DATA_W. Opcode 5 (fetch-and-increment) returns the prior value and writes the prior value plus one.
- R6: Opcode 6 (compare-and-swap) writes operand A only if the word equals operand B, and always returns the prior value. `rsp_ok` is 1 exactly when that write happened; it is 0 on every other response and whenever `rsp_valid` is low.
- R7: The response to an accepted atomic request appears two cycles after acceptance. `req_ready` stays low in the cycle after acceptance. Each accepted request yields exactly one response, in acceptance order.
- R8: While an atomic operation is in flight, an invalidation for its locked word is refused (`inv_ready` low). An invalidation for any other word is accepted. An accepted invalidation sets its word to zero.
- R9: When the request address equals the address of a presented invalidation, `req_ready` is low for that cycle, so the invalidation takes effect first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 3 | Operation code (see R2 to R6) |
| req_addr | input | ADDR_W | Word address |
| req_a | input | DATA_W | Operand A: store, swap or new value, or addend |
| req_b | input | DATA_W | Operand B: expected value for compare-and-swap |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_data | output | DATA_W | Value of the word before the operation |
| rsp_ok | output | 1 | Compare-and-swap wrote the word |
| inv_valid | input | 1 | Invalidation presented |
| inv_ready | output | 1 | Invalidation accepted this cycle |
| inv_addr | input | ADDR_W | Word to invalidate |

## Verification
The bench builds the unit with 32-bit words and a 3-bit address, so it has only eight words. With so few words, random traffic keeps hitting words that are locked or under invalidation. Small operand values let compare-and-swap both succeed and fail, and a wide addend is used to make fetch-and-add wrap. The directed part drives invalidations and back-to-back atomics into the cycle in which a word is locked. It also drives requests and invalidations to the same word in the same cycle.

// File: rtl/amo_pkg.sv
package amo_pkg;

   typedef enum logic [2:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_SWAP  = 3'd2,
      OP_TAS   = 3'd3,
      OP_FADD  = 3'd4,
      OP_FINC  = 3'd5,
      OP_CAS   = 3'd6,
      OP_RSVD  = 3'd7
   } amo_op_e;

   function automatic logic op_is_atomic(amo_op_e op);
      return (op == OP_SWAP) || (op == OP_TAS) || (op == OP_FADD) ||
             (op == OP_FINC) || (op == OP_CAS);
   endfunction

endpackage

// File: rtl/amo_storage.sv
module amo_storage #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] clr_addr
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            words[gi] <= '0;
         end else begin
            if (clr_en && (clr_addr == ADDR_W'(gi))) words[gi] <= '0;
            if (wr_en && (wr_addr == ADDR_W'(gi)))   words[gi] <= wr_data;
         end
      end
   end

   assign rd_data = words[rd_addr];

   // R8: an invalidation never lands on the word being written
   a_r8_no_clear_collision: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && clr_en) |-> (wr_addr != clr_addr));

endmodule

// File: rtl/amo_alu.sv
module amo_alu
   import amo_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  amo_op_e           op,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] new_val,
   output logic              wr_en,
   output logic              ok
);
   always_comb begin
      new_val = old_val;
      wr_en   = 1'b0;
      ok      = 1'b0;
      unique case (op)
         OP_STORE, OP_SWAP: begin
            new_val = opnd_a;
            wr_en   = 1'b1;
         end
         OP_TAS: begin
            new_val = DATA_W'(1);
            wr_en   = (old_val == '0);
         end
         OP_FADD: begin
            new_val = old_val + opnd_a;
            wr_en   = 1'b1;
         end
         OP_FINC: begin
            new_val = old_val + DATA_W'(1);
            wr_en   = 1'b1;
         end
         OP_CAS: begin
            new_val = opnd_a;
            wr_en   = (old_val == opnd_b);
            ok      = wr_en;
         end
         default: begin
            new_val = old_val;
         end
      endcase
   end

endmodule

// File: rtl/amo_lock_ctrl.sv
module amo_lock_ctrl #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   output logic              busy,
   output logic [ADDR_W-1:0] lock_addr,
   output logic              req_ready,
   output logic              inv_ready
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         lock_addr <= '0;
      end else if (busy) begin
         busy <= 1'b0;
      end else if (start) begin
         busy      <= 1'b1;
         lock_addr <= start_addr;
      end
   end

   assign req_ready = !busy && !(inv_valid && (inv_addr == req_addr));
   assign inv_ready = !(busy && (inv_addr == lock_addr));

   // R7: the lock lasts exactly one cycle after acceptance
   a_r7_lock_released: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

endmodule

// File: rtl/amo_unit.sv
module amo_unit
   import amo_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_a,
   input  logic [DATA_W-1:0] req_b,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_ok,
   input  logic              inv_valid,
   output logic              inv_ready,
   input  logic [ADDR_W-1:0] inv_addr
);
   if (DATA_W < 2 || DATA_W > 128) begin : g_bad_data_w
      $error("amo_unit: DATA_W must lie in 2..128");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("amo_unit: ADDR_W must lie in 1..10");
   end

   amo_op_e           in_op;
   amo_op_e           hold_op;
   logic [DATA_W-1:0] hold_a, hold_b;
   logic              busy;
   logic [ADDR_W-1:0] lock_addr;
   logic              acc, acc_atomic, acc_plain;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;
   amo_op_e           alu_op;
   logic [DATA_W-1:0] alu_a, alu_b, alu_new;
   logic              alu_wr, alu_ok, mem_wr, issue;

   assign in_op      = amo_op_e'(req_op);
   assign acc        = req_valid && req_ready;
   assign acc_atomic = acc && op_is_atomic(in_op);
   assign acc_plain  = acc && !op_is_atomic(in_op);

   amo_lock_ctrl #(.ADDR_W(ADDR_W)) lock_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (acc_atomic),
      .start_addr (req_addr),
      .req_addr   (req_addr),
      .inv_valid  (inv_valid),
      .inv_addr   (inv_addr),
      .busy       (busy),
      .lock_addr  (lock_addr),
      .req_ready  (req_ready),
      .inv_ready  (inv_ready)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_op <= OP_LOAD;
         hold_a  <= '0;
         hold_b  <= '0;
      end else if (acc_atomic) begin
         hold_op <= in_op;
         hold_a  <= req_a;
         hold_b  <= req_b;
      end
   end

   assign rd_addr = busy ? lock_addr : req_addr;
   assign alu_op  = busy ? hold_op   : in_op;
   assign alu_a   = busy ? hold_a    : req_a;
   assign alu_b   = busy ? hold_b    : req_b;

   amo_alu #(.DATA_W(DATA_W)) alu_i (
      .op      (alu_op),
      .old_val (rd_data),
      .opnd_a  (alu_a),
      .opnd_b  (alu_b),
      .new_val (alu_new),
      .wr_en   (alu_wr),
      .ok      (alu_ok)
   );

   assign issue  = busy || acc_plain;
   assign mem_wr = issue && alu_wr;

   amo_storage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .wr_en    (mem_wr),
      .wr_addr  (rd_addr),
      .wr_data  (alu_new),
      .clr_en   (inv_valid && inv_ready),
      .clr_addr (inv_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_ok    <= 1'b0;
      end else begin
         rsp_valid <= issue;
         rsp_ok    <= issue && alu_ok;
         if (issue) rsp_data <= rd_data;
      end
   end

   // R7: no new request is taken while an atomic holds its word
   a_r7_stall_after_atomic: assert property (@(posedge clk) disable iff (!rst_n)
      acc_atomic |=> !req_ready);

   // R7: atomic response arrives two cycles after acceptance
   a_r7_atomic_latency: assert property (@(posedge clk) disable iff (!rst_n)
      acc_atomic |=> (!rsp_valid ##1 rsp_valid));

   // R2: plain operations answer in the next cycle
   a_r2_plain_latency: assert property (@(posedge clk) disable iff (!rst_n)
      acc_plain |=> rsp_valid);

   // R6: success flag only accompanies a response
   a_r6_ok_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ok |-> rsp_valid);

   // R8: the locked word refuses invalidation in the cycle after acceptance
   a_r8_locked_inv: assert property (@(posedge clk) disable iff (!rst_n)
      acc_atomic |=> !(inv_valid && inv_ready && (inv_addr == $past(req_addr))));

endmodule

// File: tb/amo_unit_tb_top.sv
module amo_unit_tb_top;
   localparam int DW = 32;
   localparam int AW = 3;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, req_ready;
   logic [2:0]    req_op;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_a, req_b;
   logic          rsp_valid, rsp_ok;
   logic [DW-1:0] rsp_data;
   logic          inv_valid, inv_ready;
   logic [AW-1:0] inv_addr;

   always #4 clk = ~clk;

   amo_unit #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_a(req_a), .req_b(req_b),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok),
      .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_addr(inv_addr)
   );

   int checks = 0;
   int failures = 0;

   // reference state
   logic [DW-1:0] mm [NW];
   bit            m_busy;
   logic [AW-1:0] m_lock;
   logic [2:0]    m_op;
   logic [DW-1:0] m_a, m_b;
   bit            e_valid, e_ok;
   logic [DW-1:0] e_data;
   string         e_tag;

   function automatic void chk(bit good, string tag, string what,
                               logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (!good) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endfunction

   function automatic string tag_of(logic [2:0] op);
      case (op)
         3'd2:       return "R3";
         3'd3:       return "R4";
         3'd4, 3'd5: return "R5";
         3'd6:       return "R6";
         default:    return "R2";
      endcase
   endfunction

   function automatic bit atomic_op(logic [2:0] op);
      return (op >= 3'd2) && (op <= 3'd6);
   endfunction

   // behaviour of one operation on one word, from the requirements
   task automatic apply(input logic [2:0] op, input logic [AW-1:0] ad,
                        input logic [DW-1:0] a, input logic [DW-1:0] b);
      logic [DW-1:0] old;
      old     = mm[ad];
      e_data  = old;
      e_ok    = 1'b0;
      e_valid = 1'b1;
      e_tag   = tag_of(op);
      case (op)
         3'd1, 3'd2: mm[ad] = a;
         3'd3:       if (old == '0) mm[ad] = 1;
         3'd4:       mm[ad] = old + a;
         3'd5:       mm[ad] = old + 1;
         3'd6:       if (old == b) begin mm[ad] = a; e_ok = 1'b1; end
         default:    ;
      endcase
   endtask

   task automatic step(output bit accepted);
      bit conflict, e_rr, e_ir, was_valid, was_ok;
      logic [DW-1:0] was_data;
      string was_tag;
      #1;
      conflict = inv_valid && (inv_addr == req_addr);
      e_rr = !m_busy && !conflict;
      e_ir = !(m_busy && (inv_addr == m_lock));
      chk(req_ready === e_rr, m_busy ? "R7" : (conflict ? "R9" : "R2"),
          "req_ready", DW'(req_ready), DW'(e_rr));
      chk(inv_ready === e_ir, "R8", "inv_ready", DW'(inv_ready), DW'(e_ir));
      chk(rsp_valid === e_valid, e_valid ? "R7" : e_tag, "rsp_valid",
          DW'(rsp_valid), DW'(e_valid));
      chk(rsp_ok === (e_valid && e_ok), "R6", "rsp_ok", DW'(rsp_ok), DW'(e_valid && e_ok));
      if (e_valid) chk(rsp_data === e_data, e_tag, "rsp_data", rsp_data, e_data);
      was_valid = e_valid; was_ok = e_ok; was_data = e_data; was_tag = e_tag;
      e_valid = 1'b0;
      e_ok = 1'b0;
      accepted = req_valid && e_rr;
      if (m_busy) begin
         apply(m_op, m_lock, m_a, m_b);
         m_busy = 1'b0;
      end else if (accepted) begin
         if (atomic_op(req_op)) begin
            m_busy = 1'b1; m_lock = req_addr; m_op = req_op; m_a = req_a; m_b = req_b;
         end else begin
            apply(req_op, req_addr, req_a, req_b);
         end
      end
      if (!e_valid) begin e_data = was_data; e_tag = was_tag; end
      if (inv_valid && e_ir) mm[inv_addr] = '0;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      bit acc;
      req_valid = 1'b0;
      inv_valid = 1'b0;
      for (int i = 0; i < n; i++) step(acc);
   endtask

   task automatic issue(input int op, input int ad, input logic [DW-1:0] a,
                        input logic [DW-1:0] b);
      bit acc;
      req_valid = 1'b1; req_op = 3'(op); req_addr = AW'(ad); req_a = a; req_b = b;
      do step(acc); while (!acc);
      req_valid = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      failures++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      bit acc;
      rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_a = '0;
      req_b = '0; inv_valid = 1'b0; inv_addr = '0;
      for (int i = 0; i < NW; i++) mm[i] = '0;
      m_busy = 0; m_lock = '0; m_op = '0; m_a = '0; m_b = '0;
      e_valid = 0; e_ok = 0; e_data = '0; e_tag = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state at the ports
      chk(rsp_valid === 1'b0, "R1", "rsp_valid after reset", DW'(rsp_valid), 0);
      chk(rsp_ok === 1'b0, "R1", "rsp_ok after reset", DW'(rsp_ok), 0);
      chk(req_ready === 1'b1, "R1", "req_ready after reset", DW'(req_ready), 1);
      @(negedge clk);
      // R1: every word reads zero
      for (int i = 0; i < NW; i++) issue(0, i, '0, '0);
      idle(1);
      // R2: store then load; reserved opcode acts as a load
      issue(1, 1, 32'd10, '0);
      issue(0, 1, '0, '0);
      issue(7, 1, 32'd99, '0);
      // R3: swap
      issue(2, 1, 32'd7, '0);
      issue(0, 1, '0, '0);
      // R4: test-and-set on free then taken word
      issue(3, 2, '0, '0);
      issue(3, 2, '0, '0);
      // R5: wrapping add and increment
      issue(4, 1, 32'hFFFF_FFFF, '0);
      issue(5, 1, '0, '0);
      issue(4, 0, 32'h8000_0000, '0);
      issue(4, 0, 32'h8000_0001, '0);
      issue(0, 0, '0, '0);
      // R6: compare-and-swap success and failure
      issue(6, 3, 32'd9, 32'd0);
      issue(6, 3, 32'd5, 32'd0);
      issue(0, 3, '0, '0);
      // R7: back-to-back atomics
      issue(5, 4, '0, '0);
      issue(5, 4, '0, '0);
      issue(2, 4, 32'd44, '0);
      idle(2);
      // R8: invalidation of the locked word is held off, another word goes through
      issue(2, 5, 32'd33, '0);
      inv_valid = 1'b1; inv_addr = 3'd5;
      step(acc);
      step(acc);
      inv_valid = 1'b0;
      issue(0, 5, '0, '0);
      issue(2, 6, 32'd21, '0);
      inv_valid = 1'b1; inv_addr = 3'd1;
      step(acc);
      inv_valid = 1'b0;
      issue(0, 1, '0, '0);
      // R9: request and invalidation to the same word
      issue(1, 6, 32'd77, '0);
      inv_valid = 1'b1; inv_addr = 3'd6;
      req_valid = 1'b1; req_op = 3'd0; req_addr = 3'd6;
      step(acc);
      inv_valid = 1'b0;
      issue(0, 6, '0, '0);
      // R2: store of zero releases a test-and-set lock
      issue(1, 2, '0, '0);
      issue(3, 2, '0, '0);
      idle(2);
      // mixed random traffic on few words
      for (int i = 0; i < 3000; i++) begin
         req_valid = ($urandom % 4) != 0;
         req_op    = 3'($urandom % 8);
         req_addr  = AW'($urandom % NW);
         req_a     = (($urandom % 8) == 0) ? 32'($urandom) : 32'($urandom % 4);
         req_b     = 32'($urandom % 4);
         inv_valid = ($urandom % 5) == 0;
         inv_addr  = AW'($urandom % NW);
         step(acc);
      end
      idle(3);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule